// File: doc/BRIEF.md
# Runahead Entry Throttle

This block decides, each time a long-latency load miss stalls at the head of the reorder buffer, whether the core is permitted to begin a runahead episode. Two independent filters must both agree before entry is granted. The first filter is a small direct-mapped table of 2-bit saturating confidence counters, indexed by low bits of the program counter of the stalling load. It learns whether episodes started by that static load went on to uncover further last-level misses. The second filter is an overlap guard. It remembers how many instructions were pseudo-retired in the episode that just finished, and it holds off any new episode until that many instructions have retired in normal mode.

The core presents an entry request with the load's PC and reads back a combinational allow bit in the same cycle. When an episode finishes, the core reports the triggering load's PC, whether the episode was useful (at least one additional last-level miss was issued during it), and the count of pseudo-retired instructions. It also pulses a retire input once for each instruction that retires normally. The runahead machinery itself is outside this block.

Top module: `ra_entry_gate`

## Requirements
- R1: After reset every confidence counter holds 2 (weakly allow) and the blackout count is zero, so any request PC is allowed.
- R2: `allow` is 1 only while `reqValid` is 1.
- R3: A useful episode-end report increments the counter selected by `endPc`, saturating at 3; a counter of 2 or 3 lets entry through.
- R4: A useless episode-end report decrements the selected counter, saturating at 0; a counter of 0 or 1 blocks entry for that index.
- R5: The table index is PC bits [PC_LSB+IDX_W-1:PC_LSB] (bits [5:2] by default). PCs that share these bits share a counter, and PCs that differ in them train separate counters.
- R6: An episode-end report loads the blackout count with `endCount`, and no request is allowed while the blackout count is nonzero.
- R7: With no episode end in the same cycle, each `retireValid` pulse lowers a nonzero blackout count by one. Entry reopens after exactly `endCount` pulses, and further pulses keep it at zero.
- R8: When an episode-end report and a retire pulse arrive in the same cycle, the blackout count takes `endCount` and the retire pulse is not counted.
- R9: An episode-end report with `endCount` of zero leaves no blackout.
- R10: Updates from an episode-end report or a retire pulse affect `allow` from the next cycle on. `allow` in the reporting cycle reflects the state held before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Runahead entry request for a miss at the ROB head |
| reqPc | input | PC_W | PC of the load making the request |
| allow | output | 1 | Entry permitted (combinational) |
| endValid | input | 1 | Episode-end report strobe |
| endPc | input | PC_W | PC of the load that started the finished episode |
| endUseful | input | 1 | 1 if the episode issued at least one extra last-level miss |
| endCount | input | CNT_W | Instructions pseudo-retired during the finished episode |
| retireValid | input | 1 | One instruction retired in normal mode this cycle |

## Verification
Directed sequences drive one counter up and down across its saturation points and across the 1-to-2 threshold. This separates wrong clamping from a wrong threshold. Aliasing pairs of PCs, which differ only outside the index bits, are set against PCs that differ inside them, which exposes a wrong index slice. The blackout path is tried with exact retire counts, with surplus retires, with a zero length, and with an end report coinciding with a retire pulse, which shows up off-by-one, wrap-below-zero and priority faults. A long constrained-random run then mixes requests, reports and retires over a small PC pool and compares every cycle's `allow` against a bench model.

// File: rtl/ra_gate_pkg.sv
package ra_gate_pkg;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_INIT = 2'd2;
  localparam logic [CTR_W-1:0] CTR_MAX  = 2'd3;

  typedef struct packed {
    logic ctrInc;
    logic ctrDec;
    logic boLoad;
    logic boDec;
  } gateStrobe_t;
endpackage

// File: rtl/ra_gate_ctrl.sv
module ra_gate_ctrl
  import ra_gate_pkg::*;
(
  input  logic        reqValid,
  input  logic        endValid,
  input  logic        endUseful,
  input  logic        retireValid,
  input  logic        reqAgree,
  input  logic        boZero,
  output gateStrobe_t strobe,
  output logic        allow
);
  always_comb begin
    strobe        = '0;
    strobe.ctrInc = endValid && endUseful;
    strobe.ctrDec = endValid && !endUseful;
    strobe.boLoad = endValid;
    strobe.boDec  = !endValid && retireValid && !boZero;
  end

  assign allow = reqValid && reqAgree && boZero;
endmodule

// File: rtl/ra_gate_dp.sv
module ra_gate_dp
  import ra_gate_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int PC_LSB = 2,
  parameter int CNT_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStrobe_t      strobe,
  input  logic [PC_W-1:0]  reqPc,
  input  logic [PC_W-1:0]  endPc,
  input  logic [CNT_W-1:0] endCount,
  output logic             reqAgree,
  output logic             boZero,
  output logic [CNT_W-1:0] boCount
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CTR_W-1:0] ctrTable [ENTRIES];
  logic [IDX_W-1:0] reqIdx;
  logic [IDX_W-1:0] endIdx;
  logic [CTR_W-1:0] endCtr;

  assign reqIdx = reqPc[PC_LSB +: IDX_W];
  assign endIdx = endPc[PC_LSB +: IDX_W];
  assign endCtr = ctrTable[endIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) ctrTable[e] <= CTR_INIT;
    end else if (strobe.ctrInc && endCtr != CTR_MAX) begin
      ctrTable[endIdx] <= endCtr + 1'b1;
    end else if (strobe.ctrDec && endCtr != '0) begin
      ctrTable[endIdx] <= endCtr - 1'b1;
    end
  end

  assign reqAgree = ctrTable[reqIdx][CTR_W-1];

  always_ff @(posedge clk) begin
    if (!rstN)              boCount <= '0;
    else if (strobe.boLoad) boCount <= endCount;
    else if (strobe.boDec)  boCount <= boCount - 1'b1;
  end

  assign boZero = (boCount == '0);
endmodule

// File: rtl/ra_entry_gate.sv
module ra_entry_gate
  import ra_gate_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 4,
  parameter int PC_LSB = 2,
  parameter int CNT_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [PC_W-1:0]  reqPc,
  output logic             allow,
  input  logic             endValid,
  input  logic [PC_W-1:0]  endPc,
  input  logic             endUseful,
  input  logic [CNT_W-1:0] endCount,
  input  logic             retireValid
);
  gateStrobe_t      strobe;
  logic             reqAgree;
  logic             boZero;
  logic [CNT_W-1:0] boCount;

  ra_gate_ctrl u_ctrl (
    .reqValid    (reqValid),
    .endValid    (endValid),
    .endUseful   (endUseful),
    .retireValid (retireValid),
    .reqAgree    (reqAgree),
    .boZero      (boZero),
    .strobe      (strobe),
    .allow       (allow)
  );

  ra_gate_dp #(
    .PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB), .CNT_W(CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqPc    (reqPc),
    .endPc    (endPc),
    .endCount (endCount),
    .reqAgree (reqAgree),
    .boZero   (boZero),
    .boCount  (boCount)
  );
endmodule

// File: rtl/ra_gate_chk.sv
module ra_gate_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             allow,
  input logic             endValid,
  input logic [CNT_W-1:0] endCount,
  input logic             retireValid,
  input logic [CNT_W-1:0] boCount
);
  assert_allow_needs_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    allow |-> reqValid);

  assert_blackout_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    endValid |=> boCount == $past(endCount));

  assert_blackout_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (boCount != '0) |-> !allow);

  assert_retire_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!endValid && retireValid && boCount != '0) |=> boCount == $past(boCount) - 1'b1);

  assert_zero_floor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!endValid && boCount == '0) |=> boCount == '0);

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!endValid && !retireValid) |=> $stable(boCount));
endmodule

bind ra_entry_gate ra_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .allow       (allow),
  .endValid    (endValid),
  .endCount    (endCount),
  .retireValid (retireValid),
  .boCount     (boCount)
);

// File: tb/ra_entry_gate_bench.sv
module ra_entry_gate_bench;
  localparam int PC_W = 32, IDX_W = 4, PC_LSB = 2, CNT_W = 10;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 0;
  logic rstN = 0;
  logic reqValid = 0, endValid = 0, endUseful = 0, retireValid = 0;
  logic [PC_W-1:0] reqPc = '0, endPc = '0;
  logic [CNT_W-1:0] endCount = '0;
  logic allow;

  int checks = 0, errors = 0;
  int mCtr [ENTRIES];
  int mBo;

  always #10 clk = ~clk;

  ra_entry_gate #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB), .CNT_W(CNT_W)) u_ra_entry_gate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPc(reqPc), .allow(allow),
    .endValid(endValid), .endPc(endPc), .endUseful(endUseful), .endCount(endCount),
    .retireValid(retireValid)
  );

  function automatic int idxOf(logic [PC_W-1:0] pc);
    return int'((pc >> PC_LSB) & (ENTRIES - 1));
  endfunction

  function automatic bit expAllow(bit rv, logic [PC_W-1:0] pc);
    return rv && (mBo == 0) && (mCtr[idxOf(pc)] >= 2);
  endfunction

  function automatic string autoTag(bit rv, logic [PC_W-1:0] pc);
    if (!rv) return "R2";
    if (mBo != 0) return "R6";
    if (mCtr[idxOf(pc)] < 2) return "R4";
    return "R3";
  endfunction

  task automatic modelReset();
    for (int e = 0; e < ENTRIES; e++) mCtr[e] = 2;
    mBo = 0;
  endtask

  // Drive one cycle at negedge, check allow before the edge, update model after.
  task automatic step(bit rv, logic [PC_W-1:0] rpc, bit ev, logic [PC_W-1:0] epc,
                      bit eu, int ec, bit ret, string tag);
    string t;
    bit exp;
    @(negedge clk);
    reqValid = rv; reqPc = rpc; endValid = ev; endPc = epc;
    endUseful = eu; endCount = CNT_W'(ec); retireValid = ret;
    #2;
    exp = expAllow(rv, rpc);
    t = (tag == "") ? autoTag(rv, rpc) : tag;
    checks++;
    if (allow !== exp) begin
      errors++;
      $display("FAIL %s: allow=%0b expected=%0b pc=%h bo=%0d", t, allow, exp, rpc, mBo);
    end
    @(posedge clk);
    if (ev) begin
      int i = idxOf(epc);
      if (eu && mCtr[i] < 3) mCtr[i]++;
      else if (!eu && mCtr[i] > 0) mCtr[i]--;
      mBo = ec;
    end else if (ret && mBo > 0) begin
      mBo--;
    end
  endtask

  task automatic probe(logic [PC_W-1:0] pc, string tag);
    step(1, pc, 0, '0, 0, 0, 0, tag);
  endtask

  task automatic train(logic [PC_W-1:0] pc, bit useful, string tag);
    step(0, '0, 1, pc, useful, 0, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset state allows every index
    for (int e = 0; e < ENTRIES; e++) probe(PC_W'(e << PC_LSB), "R1");
    probe(32'hdead_beef, "R1");
    // R2: no request, no allow
    step(0, 32'h40, 0, '0, 0, 0, 0, "R2");

    // R3: saturate up at 3, one useless keeps allow (3->2), second blocks (R4)
    for (int k = 0; k < 4; k++) train(32'h100, 1, "R3");
    probe(32'h100, "R3");
    train(32'h100, 0, "R3");
    probe(32'h100, "R3");
    train(32'h100, 0, "R4");
    probe(32'h100, "R4");
    // R4: saturate down at 0, then two useful needed to reopen
    for (int k = 0; k < 4; k++) train(32'h100, 0, "R4");
    train(32'h100, 1, "R4");
    probe(32'h100, "R4");
    train(32'h100, 1, "R4");
    probe(32'h100, "R4");

    // R5: aliasing outside index bits, independence inside
    train(32'h0000_0208, 0, "R5");
    probe(32'hffff_fc0b, "R5");
    probe(32'h0000_020c, "R5");
    probe(32'h0000_0209, "R5");

    // R10: allow in the reporting cycle uses old counter
    step(1, 32'h0000_0208, 1, 32'h0000_0208, 1, 0, 0, "R10");
    probe(32'h0000_0208, "R10");

    // R6/R7: blackout of 3, exact release
    step(0, '0, 1, 32'h300, 1, 3, 0, "R6");
    probe(32'h300, "R6");
    step(1, 32'h300, 0, '0, 0, 0, 1, "R7");
    step(1, 32'h300, 0, '0, 0, 0, 1, "R7");
    probe(32'h300, "R7");
    step(1, 32'h300, 0, '0, 0, 0, 1, "R7");
    probe(32'h300, "R7");
    step(1, 32'h300, 0, '0, 0, 0, 1, "R7");
    step(1, 32'h300, 0, '0, 0, 0, 1, "R7");
    probe(32'h300, "R7");

    // R8: end report with retire in same cycle, retire not counted
    step(0, '0, 1, 32'h300, 1, 1, 1, "R8");
    probe(32'h300, "R8");
    step(1, 32'h300, 0, '0, 0, 0, 1, "R8");
    probe(32'h300, "R8");

    // R9: zero-length episode leaves no blackout
    step(0, '0, 1, 32'h300, 1, 0, 0, "R9");
    probe(32'h300, "R9");

    // Random phase over a small PC pool
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] rpc = PC_W'(($urandom % 6) << PC_LSB) | PC_W'(($urandom % 3) << 12);
      logic [PC_W-1:0] epc = PC_W'(($urandom % 6) << PC_LSB) | PC_W'(($urandom % 3) << 12);
      bit ev = ($urandom % 8) == 0;
      step(($urandom % 2) == 1, rpc, ev, epc, ($urandom % 2) == 1,
           int'($urandom % 6), ($urandom % 2) == 1, "");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule